// File: doc/BRIEF.md
# ECC Error Capture Register

This block records memory ECC events for an SDRAM controller. On every read the ECC decoder may raise a one-cycle pulse that marks a corrected (single-bit) or an uncorrectable (multi-bit) error. The pulse comes with the failing physical address and, for corrected errors, the 8-bit syndrome. The block keeps the first such event in one 32-bit status word. Software reads that word and writes it over a plain write-enable/data register port. A logged event stays put until software acknowledges it.

The status word holds three software-owned control bits: a scrub inhibit, an NMI enable for corrected errors and a bus-error enable for uncorrectable errors. It also holds two write-1-to-clear event flags and the read-only capture fields. Only the upper 19 bits of the failing address are kept, so any two addresses that differ only in their low 13 bits log the same value. From the flags and enables the block drives level-sensitive NMI and bus-error requests. After any corrected read it also issues a one-cycle scrub write-back request carrying the full address, unless scrubbing is inhibited.

Top module: `ecc_err_log`

## Requirements
- R1: After synchronous reset every bit of the status word reads 0, and `nmi_req_o`, `buserr_req_o` and `scrub_req_o` are low.
- R2: A register write sets bit 31 (scrub inhibit), bit 3 (bus-error enable) and bit 2 (NMI enable) from the written data, visible one cycle later. Writes never change bits 30:4.
- R3: When both flags are clear, a corrected-error pulse (`ecc_sbe_i`=1, `ecc_mbe_i`=0) sets bit 0 on the next cycle. In that same cycle, bits 30:12 hold `ecc_addr_i[31:13]` and bits 11:4 hold `ecc_syn_i`.
- R4: When both flags are clear, an uncorrectable pulse (`ecc_mbe_i`=1, with or without `ecc_sbe_i`) sets bit 1 and stores the address the same way as R3, and bits 11:4 read 0. Bits 0 and 1 are never both 1.
- R5: While bit 0 or bit 1 is set and is not being cleared, error pulses change neither the flags nor bits 30:4.
- R6: Writing 1 to bit 0 clears the corrected-error flag, and writing 1 to bit 1 clears the uncorrectable flag. Writing 0 to either bit leaves it as it is. A new capture is possible only once both flags read 0.
- R7: If a write clears the set flag in the same cycle as a new error pulse, the new error is captured as in R3/R4.
- R8: `nmi_req_o` equals bit 0 AND bit 2, and `buserr_req_o` equals bit 1 AND bit 3. Both follow the status word in the same cycle.
- R9: One cycle after a corrected-only pulse, `scrub_req_o` is high for one cycle with `scrub_addr_o` equal to the full pulse address, provided bit 31 was 0 in the pulse cycle. This holds whatever the flags are.
- R10: No scrub request follows a pulse if bit 31 was 1 or if `ecc_mbe_i` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_sbe_i | input | 1 | Corrected-error pulse for this read |
| ecc_mbe_i | input | 1 | Uncorrectable-error pulse for this read |
| ecc_addr_i | input | 32 | Physical address of the read |
| ecc_syn_i | input | 8 | Syndrome of the read |
| reg_wr_i | input | 1 | Status word write strobe |
| reg_wdata_i | input | 32 | Status word write data |
| reg_rdata_o | output | 32 | Current status word |
| nmi_req_o | output | 1 | NMI request, level |
| buserr_req_o | output | 1 | Bus-error request, level |
| scrub_req_o | output | 1 | One-cycle scrub write-back request |
| scrub_addr_o | output | 32 | Address to scrub, valid with `scrub_req_o` |

## Verification
Directed phases cover three cases in turn. An isolated corrected pulse and an isolated uncorrectable pulse show whether the syndrome is stored or zeroed. Simultaneous pulses show the uncorrectable priority. Pulses arriving while a flag is held tell first-error retention apart from overwrite. Further patterns separate the other behaviours. Write-0, wrong-flag and correct-flag clears tell the write-1-to-clear rule apart from plain write. A clear in the same cycle as a pulse shows whether a new error is lost or captured. Scrub inhibit toggled around corrected pulses separates the scrub path from the logging path. A long random phase then mixes pulses, clears and control writes while a behavioural model is compared every cycle.

// File: rtl/ecc_elog_pkg.sv
package ecc_elog_pkg;

    localparam int ELOG_ADDR_W = 32;
    localparam int ELOG_CAP_W  = 19;
    localparam int ELOG_SYN_W  = 8;
    localparam int ELOG_CTL_N  = 2;
    localparam int ELOG_FLG_N  = 2;
    localparam int ELOG_REG_W  = 1 + ELOG_CAP_W + ELOG_SYN_W + ELOG_CTL_N + ELOG_FLG_N;

    localparam int POS_SBE       = 0;
    localparam int POS_MBE       = 1;
    localparam int POS_NMI_EN    = 2;
    localparam int POS_BE_EN     = 3;
    localparam int POS_SYN_LO    = ELOG_FLG_N + ELOG_CTL_N;
    localparam int POS_CAP_LO    = POS_SYN_LO + ELOG_SYN_W;
    localparam int POS_SCRUB_DIS = POS_CAP_LO + ELOG_CAP_W;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_CORR    = 2'd1,
        EV_UNCORR  = 2'd2
    } elog_kind_e;

    typedef struct packed {
        elog_kind_e              kind;
        logic [ELOG_CAP_W-1:0]   page;
        logic [ELOG_SYN_W-1:0]   syn;
    } elog_evt_t;

    typedef struct packed {
        logic scrub_dis;
        logic be_en;
        logic nmi_en;
    } elog_ctrl_t;

    function automatic elog_kind_e classify(input logic sbe, input logic mbe);
        if (mbe)      return EV_UNCORR;
        else if (sbe) return EV_CORR;
        else          return EV_NONE;
    endfunction

    function automatic elog_evt_t make_evt(input logic sbe, input logic mbe,
                                           input logic [ELOG_ADDR_W-1:0] addr,
                                           input logic [ELOG_SYN_W-1:0] syn);
        elog_evt_t e;
        e.kind = classify(sbe, mbe);
        e.page = addr[ELOG_ADDR_W-1 -: ELOG_CAP_W];
        e.syn  = (e.kind == EV_CORR) ? syn : '0;
        return e;
    endfunction

    function automatic logic [ELOG_REG_W-1:0] pack_status(input elog_ctrl_t ctl,
                                                          input logic sbe_f,
                                                          input logic mbe_f,
                                                          input logic [ELOG_CAP_W-1:0] page,
                                                          input logic [ELOG_SYN_W-1:0] syn);
        logic [ELOG_REG_W-1:0] w;
        w = '0;
        w[POS_SCRUB_DIS]                   = ctl.scrub_dis;
        w[POS_CAP_LO +: ELOG_CAP_W]        = page;
        w[POS_SYN_LO +: ELOG_SYN_W]        = syn;
        w[POS_BE_EN]                       = ctl.be_en;
        w[POS_NMI_EN]                      = ctl.nmi_en;
        w[POS_MBE]                         = mbe_f;
        w[POS_SBE]                         = sbe_f;
        return w;
    endfunction

endpackage

// File: rtl/ecc_elog_ctrl.sv
module ecc_elog_ctrl
    import ecc_elog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  elog_ctrl_t wr_ctl_i,
    output elog_ctrl_t ctl_o
);

    elog_ctrl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_i) begin
            ctl_q <= wr_ctl_i;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/ecc_elog_capture.sv
module ecc_elog_capture
    import ecc_elog_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  elog_evt_t             evt_i,
    input  logic                  clr_sbe_i,
    input  logic                  clr_mbe_i,
    output logic                  sbe_f_o,
    output logic                  mbe_f_o,
    output logic [ELOG_CAP_W-1:0] page_o,
    output logic [ELOG_SYN_W-1:0] syn_o
);

    logic                  sbe_q, mbe_q;
    logic [ELOG_CAP_W-1:0] page_q;
    logic [ELOG_SYN_W-1:0] syn_q;
    logic                  sbe_keep, mbe_keep, armed, take;

    always_comb begin
        sbe_keep = sbe_q & ~clr_sbe_i;
        mbe_keep = mbe_q & ~clr_mbe_i;
        armed    = ~sbe_keep & ~mbe_keep;
        take     = armed && (evt_i.kind != EV_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sbe_q  <= 1'b0;
            mbe_q  <= 1'b0;
            page_q <= '0;
            syn_q  <= '0;
        end else if (take) begin
            sbe_q  <= (evt_i.kind == EV_CORR);
            mbe_q  <= (evt_i.kind == EV_UNCORR);
            page_q <= evt_i.page;
            syn_q  <= evt_i.syn;
        end else begin
            sbe_q  <= sbe_keep;
            mbe_q  <= mbe_keep;
        end
    end

    assign sbe_f_o = sbe_q;
    assign mbe_f_o = mbe_q;
    assign page_o  = page_q;
    assign syn_o   = syn_q;

endmodule

// File: rtl/ecc_elog_scrub.sv
module ecc_elog_scrub
    import ecc_elog_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  elog_kind_e             kind_i,
    input  logic [ELOG_ADDR_W-1:0] addr_i,
    input  logic                   scrub_dis_i,
    output logic                   req_o,
    output logic [ELOG_ADDR_W-1:0] addr_o
);

    logic                   req_q;
    logic [ELOG_ADDR_W-1:0] addr_q;
    logic                   fire;

    assign fire = (kind_i == EV_CORR) && !scrub_dis_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            req_q <= fire;
            if (fire) begin
                addr_q <= addr_i;
            end
        end
    end

    assign req_o  = req_q;
    assign addr_o = addr_q;

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_elog_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ecc_sbe_i,
    input  logic                   ecc_mbe_i,
    input  logic [ELOG_ADDR_W-1:0] ecc_addr_i,
    input  logic [ELOG_SYN_W-1:0]  ecc_syn_i,
    input  logic                   reg_wr_i,
    input  logic [ELOG_REG_W-1:0]  reg_wdata_i,
    output logic [ELOG_REG_W-1:0]  reg_rdata_o,
    output logic                   nmi_req_o,
    output logic                   buserr_req_o,
    output logic                   scrub_req_o,
    output logic [ELOG_ADDR_W-1:0] scrub_addr_o
);

    elog_evt_t             evt;
    elog_ctrl_t            wr_ctl, ctl;
    logic                  clr_sbe, clr_mbe;
    logic                  sbe_f, mbe_f;
    logic [ELOG_CAP_W-1:0] page;
    logic [ELOG_SYN_W-1:0] syn;
    logic                  unused_wbits;

    assign evt = make_evt(ecc_sbe_i, ecc_mbe_i, ecc_addr_i, ecc_syn_i);

    assign wr_ctl.scrub_dis = reg_wdata_i[POS_SCRUB_DIS];
    assign wr_ctl.be_en     = reg_wdata_i[POS_BE_EN];
    assign wr_ctl.nmi_en    = reg_wdata_i[POS_NMI_EN];
    assign clr_sbe          = reg_wr_i & reg_wdata_i[POS_SBE];
    assign clr_mbe          = reg_wr_i & reg_wdata_i[POS_MBE];
    assign unused_wbits     = ^reg_wdata_i[POS_SCRUB_DIS-1:POS_SYN_LO];

    ecc_elog_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr_i),
        .wr_ctl_i (wr_ctl),
        .ctl_o    (ctl)
    );

    ecc_elog_capture i_capture (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .clr_sbe_i (clr_sbe),
        .clr_mbe_i (clr_mbe),
        .sbe_f_o   (sbe_f),
        .mbe_f_o   (mbe_f),
        .page_o    (page),
        .syn_o     (syn)
    );

    ecc_elog_scrub i_scrub (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (evt.kind),
        .addr_i      (ecc_addr_i),
        .scrub_dis_i (ctl.scrub_dis),
        .req_o       (scrub_req_o),
        .addr_o      (scrub_addr_o)
    );

    assign reg_rdata_o  = pack_status(ctl, sbe_f, mbe_f, page, syn);
    assign nmi_req_o    = sbe_f & ctl.nmi_en;
    assign buserr_req_o = mbe_f & ctl.be_en;

endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_elog_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   ecc_sbe_i,
    input logic                   ecc_mbe_i,
    input logic [ELOG_ADDR_W-1:0] ecc_addr_i,
    input logic [ELOG_SYN_W-1:0]  ecc_syn_i,
    input logic                   reg_wr_i,
    input logic [ELOG_REG_W-1:0]  reg_wdata_i,
    input logic [ELOG_REG_W-1:0]  reg_rdata_o,
    input logic                   nmi_req_o,
    input logic                   buserr_req_o,
    input logic                   scrub_req_o,
    input logic [ELOG_ADDR_W-1:0] scrub_addr_o
);

    logic clearing;
    assign clearing = reg_wr_i && ((reg_wdata_i[POS_MBE:POS_SBE] & reg_rdata_o[POS_MBE:POS_SBE]) != '0);

    // R1
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (reg_rdata_o == '0) && !nmi_req_o && !buserr_req_o && !scrub_req_o);

    // R3
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[POS_MBE:POS_SBE] == '0 && ecc_sbe_i && !ecc_mbe_i) |=>
        reg_rdata_o[POS_SBE] && (reg_rdata_o[POS_CAP_LO +: ELOG_CAP_W] == $past(ecc_addr_i[ELOG_ADDR_W-1 -: ELOG_CAP_W]))
        && (reg_rdata_o[POS_SYN_LO +: ELOG_SYN_W] == $past(ecc_syn_i)));

    // R4
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_rdata_o[POS_SBE] && reg_rdata_o[POS_MBE]));

    // R5
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata_o[POS_MBE:POS_SBE] != '0 && !clearing) |=>
        $stable(reg_rdata_o[POS_SCRUB_DIS-1:POS_SYN_LO]) && $stable(reg_rdata_o[POS_MBE:POS_SBE]));

    // R6
    p_w0_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_wdata_i[POS_MBE:POS_SBE] == '0) |=>
        (($past(reg_rdata_o[POS_MBE:POS_SBE]) == '0) || $stable(reg_rdata_o[POS_MBE:POS_SBE])));

    // R8
    p_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (nmi_req_o == (reg_rdata_o[POS_SBE] && reg_rdata_o[POS_NMI_EN])) &&
        (buserr_req_o == (reg_rdata_o[POS_MBE] && reg_rdata_o[POS_BE_EN])));

    // R9
    p_scrub_r9: assert property (@(posedge clk) disable iff (rst)
        (ecc_sbe_i && !ecc_mbe_i && !reg_rdata_o[POS_SCRUB_DIS]) |=>
        scrub_req_o && (scrub_addr_o == $past(ecc_addr_i)));

    // R10
    p_noscrub_r10: assert property (@(posedge clk) disable iff (rst)
        (!ecc_sbe_i || ecc_mbe_i || reg_rdata_o[POS_SCRUB_DIS]) |=> !scrub_req_o);

endmodule

bind ecc_err_log ecc_err_log_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .ecc_sbe_i    (ecc_sbe_i),
    .ecc_mbe_i    (ecc_mbe_i),
    .ecc_addr_i   (ecc_addr_i),
    .ecc_syn_i    (ecc_syn_i),
    .reg_wr_i     (reg_wr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .nmi_req_o    (nmi_req_o),
    .buserr_req_o (buserr_req_o),
    .scrub_req_o  (scrub_req_o),
    .scrub_addr_o (scrub_addr_o)
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ecc_sbe_i = 1'b0;
    logic        ecc_mbe_i = 1'b0;
    logic [31:0] ecc_addr_i = '0;
    logic [7:0]  ecc_syn_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        nmi_req_o, buserr_req_o, scrub_req_o;
    logic [31:0] scrub_addr_o;

    always #2 clk = ~clk;

    ecc_err_log i_ecc_err_log (
        .clk          (clk),
        .rst          (rst),
        .ecc_sbe_i    (ecc_sbe_i),
        .ecc_mbe_i    (ecc_mbe_i),
        .ecc_addr_i   (ecc_addr_i),
        .ecc_syn_i    (ecc_syn_i),
        .reg_wr_i     (reg_wr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .nmi_req_o    (nmi_req_o),
        .buserr_req_o (buserr_req_o),
        .scrub_req_o  (scrub_req_o),
        .scrub_addr_o (scrub_addr_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_tag = "R1";

    // reference model state
    bit        m_dis, m_be, m_nmi, m_s, m_m;
    bit [18:0] m_page;
    bit [7:0]  m_syn;
    bit        m_scrub;
    bit [31:0] m_scrub_addr;

    function automatic bit [31:0] m_word();
        return {m_dis, m_page, m_syn, m_be, m_nmi, m_m, m_s};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_dis = 0; m_be = 0; m_nmi = 0; m_s = 0; m_m = 0;
        m_page = '0; m_syn = '0; m_scrub = 0; m_scrub_addr = '0;
    endtask

    task automatic model_clock();
        bit s, m;
        m_scrub = ecc_sbe_i && !ecc_mbe_i && !m_dis;
        if (m_scrub) m_scrub_addr = ecc_addr_i;
        s = m_s && !(reg_wr_i && reg_wdata_i[0]);
        m = m_m && !(reg_wr_i && reg_wdata_i[1]);
        if (!s && !m && (ecc_sbe_i || ecc_mbe_i)) begin
            m_page = ecc_addr_i[31:13];
            if (ecc_mbe_i) begin m = 1; m_syn = 8'h00; end
            else begin s = 1; m_syn = ecc_syn_i; end
        end
        m_s = s; m_m = m;
        if (reg_wr_i) begin
            m_dis = reg_wdata_i[31]; m_be = reg_wdata_i[3]; m_nmi = reg_wdata_i[2];
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, reg_rdata_o, m_word());
        chk("R8 nmi", {31'd0, nmi_req_o}, {31'd0, m_s & m_nmi});
        chk("R8 buserr", {31'd0, buserr_req_o}, {31'd0, m_m & m_be});
        chk(m_scrub ? "R9 scrub" : "R10 scrub", {31'd0, scrub_req_o}, {31'd0, m_scrub});
        if (m_scrub) chk("R9 scrub_addr", scrub_addr_o, m_scrub_addr);
    endtask

    // drive at negedge, clock, update model, compare at next negedge
    task automatic step(input bit wr, input bit [31:0] wd, input bit sbe, input bit mbe,
                        input bit [31:0] addr, input bit [7:0] syn);
        reg_wr_i = wr; reg_wdata_i = wd; ecc_sbe_i = sbe; ecc_mbe_i = mbe;
        ecc_addr_i = addr; ecc_syn_i = syn;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 32'h0, 8'h0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_tag = "R1 reset";
        compare_all();

        // R2: control bits writable, RO fields ignore writes
        cur_tag = "R2 ctrl";
        step(1, 32'hFFFF_FFFC, 0, 0, 0, 0);
        chk("R2 readback", reg_rdata_o, 32'h8000_000C);
        step(1, 32'h0000_000C, 0, 0, 0, 0);

        // R3: corrected capture
        cur_tag = "R3 sbe";
        step(0, 0, 1, 0, 32'hDEAD_BEEF, 8'h5A);
        chk("R3 fields", reg_rdata_o, {1'b0, 19'h6F56D, 8'h5A, 4'b1101});
        chk("R9 scrub_addr direct", scrub_addr_o, 32'hDEAD_BEEF);
        chk("R8 nmi direct", {31'd0, nmi_req_o}, 32'd1);

        // R5: first error held
        cur_tag = "R5 hold";
        step(0, 0, 1, 0, 32'h1234_5678, 8'h11);
        step(0, 0, 0, 1, 32'h8765_4321, 8'h22);
        step(0, 0, 1, 1, 32'hFFFF_FFFF, 8'h33);
        chk("R5 held", reg_rdata_o, {1'b0, 19'h6F56D, 8'h5A, 4'b1101});

        // R6: write 0 / wrong flag does nothing; right flag clears
        cur_tag = "R6 clear";
        step(1, 32'h0000_000C, 0, 0, 0, 0);
        step(1, 32'h0000_000E, 0, 0, 0, 0);
        chk("R6 still set", {31'd0, reg_rdata_o[0]}, 32'd1);
        step(1, 32'h0000_000D, 0, 0, 0, 0);
        chk("R6 cleared", {30'd0, reg_rdata_o[1:0]}, 32'd0);

        // R4: uncorrectable capture, syndrome zero, priority over sbe
        cur_tag = "R4 mbe";
        step(0, 0, 0, 1, 32'hA5A5_0000, 8'hEE);
        chk("R4 fields", reg_rdata_o, {1'b0, 19'h52D28, 8'h00, 4'b1110});
        chk("R8 buserr direct", {31'd0, buserr_req_o}, 32'd1);
        step(1, 32'h0000_0003, 0, 0, 0, 0);
        step(0, 0, 1, 1, 32'h0000_4000, 8'h77);
        chk("R4 both pulses", {30'd0, reg_rdata_o[1:0]}, 32'd2);
        chk("R10 no scrub on mbe", {31'd0, scrub_req_o}, 32'd0);

        // R7: clear and new error in same cycle
        cur_tag = "R7 race";
        step(1, 32'h0000_0002, 1, 0, 32'h0BAD_F00D, 8'h3C);
        chk("R7 new captured", reg_rdata_o, {1'b0, 19'h05D6F, 8'h3C, 4'b0001});

        // R10: scrub inhibit
        cur_tag = "R10 inhibit";
        step(1, 32'h8000_0001, 0, 0, 0, 0);
        step(0, 0, 1, 0, 32'h0000_1000, 8'h01);
        chk("R10 no scrub", {31'd0, scrub_req_o}, 32'd0);
        step(1, 32'h0000_0001, 0, 0, 0, 0);

        // R8: enables toggled with flags held
        cur_tag = "R8 enables";
        step(0, 0, 1, 0, 32'h4000_0000, 8'h09);
        step(1, 32'h0000_0004, 0, 0, 0, 0);
        step(1, 32'h0000_0000, 0, 0, 0, 0);
        idle(2);

        // random mix
        cur_tag = "R5 random";
        for (int i = 0; i < 600; i++) begin
            int r;
            bit wr, sbe, mbe;
            bit [31:0] wd;
            r   = $urandom_range(0, 99);
            sbe = (r < 30);
            mbe = (r >= 25 && r < 40);
            wr  = ($urandom_range(0, 9) < 3);
            wd  = $urandom();
            step(wr, wd, sbe, mbe, $urandom(), 8'($urandom()));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule